// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block resolves the 12-bit byte address used to reach the register file of a small 8-bit controller. The 4096-byte space is cut into sixteen 256-byte banks. An instruction carries one operand byte. That byte is widened to a full address in one of three ways: joined under a software-written bank number, folded into a fixed 256-byte window, or ignored in favour of a pointer register that holds the whole address.

The window is built from the lower half of bank 0 (general-purpose bytes) and the upper half of bank 15 (the special-function area). It is reachable whatever bank number is loaded. The resolved address is registered and presented on `addr_o`. A synchronous byte memory placed behind the address lets reads and writes through every mode be observed at the ports. The bank and pointer registers can be read back.

Top module: `dmem_addr_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `addr_o`, `rdata_o`, `bank_o` and `ptr_o` are all zero after that edge.
- R2: With `indirect_i`=0 and `access_i`=0, `addr_o` after the edge equals {bank[3:0], operand[7:0]}, where bank is the bank register value before that edge.
- R3: With `indirect_i`=0, `access_i`=1 and operand bit 7 = 0, `addr_o` equals 12'h000 + operand (000h..07Fh), whatever the bank register holds.
- R4: With `indirect_i`=0, `access_i`=1 and operand bit 7 = 1, `addr_o` equals 12'hF00 + operand (F80h..FFFh), whatever the bank register holds.
- R5: With `indirect_i`=1, `addr_o` equals the low 12 bits of the pointer register; `access_i` and `operand_i` have no effect on it.
- R6: A bank write keeps only `bank_wdata[3:0]`; `bank_o[7:4]` always reads zero.
- R7: A pointer write stores all 16 bits, which read back on `ptr_o` one cycle later; bits 15:12 do not reach `addr_o`.
- R8: A bank or pointer write takes effect for addresses resolved in the following cycle; an address resolved in the write cycle uses the old value.
- R9: With `mem_req`=1 and `mem_we`=1 the byte `mem_wdata` is stored at the resolved address. With `mem_req`=1, `rdata_o` after the edge shows the byte held at that address before the edge, so a write cycle returns the old byte. With `mem_req`=0, `rdata_o` holds its value.
- R10: One physical byte reached through different modes (direct, window, pointer) is the same storage location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bank_we | input | 1 | Load the bank register |
| bank_wdata | input | 8 | Bank register write data (low 4 bits kept) |
| ptr_we | input | 1 | Load the pointer register |
| ptr_wdata | input | 16 | Pointer register write data |
| indirect_i | input | 1 | 1: address comes from the pointer register |
| access_i | input | 1 | 1: operand goes through the fixed window; 0: banked |
| operand_i | input | 8 | Operand byte from the instruction |
| mem_req | input | 1 | Access the byte memory this cycle |
| mem_we | input | 1 | Access is a write |
| mem_wdata | input | 8 | Byte to write |
| addr_o | output | 12 | Registered resolved address |
| rdata_o | output | 8 | Registered read byte |
| bank_o | output | 8 | Bank register readback |
| ptr_o | output | 16 | Pointer register readback |

## Verification
The bench builds the block with its default parameters: a 4-bit bank number, an 8-bit operand, a 16-bit pointer and a full 4096-byte memory. Every bank is reachable at this size, and so are both halves of the window, including the 07Fh/F80h seam. The pointer's upper nibble is present and is discarded from the address. Because the memory spans the whole address space, bytes written in one mode can be read back in another to show aliasing, and bank or pointer writes issued in the same cycle as a use expose the one-cycle update.

// File: rtl/dau_pkg.sv
package dau_pkg;
  typedef enum logic [1:0] {
    SRC_BANKED  = 2'd0,
    SRC_WINDOW  = 2'd1,
    SRC_POINTER = 2'd2
  } addr_src_e;

  function automatic addr_src_e pick_src(input logic indirect, input logic window);
    if (indirect)    return SRC_POINTER;
    else if (window) return SRC_WINDOW;
    else             return SRC_BANKED;
  endfunction
endpackage

// File: rtl/dau_bank_reg.sv
module dau_bank_reg #(
  parameter int BANK_W = 4,
  parameter int REG_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [BANK_W-1:0] bank,
  output logic [REG_W-1:0]  readback
);
  localparam int PAD_W = REG_W - BANK_W;

  logic unused_upper;
  assign unused_upper = ^wdata[REG_W-1:BANK_W];

  always_ff @(posedge clk) begin
    if (rst)     bank <= '0;
    else if (we) bank <= wdata[BANK_W-1:0];
  end

  assign readback = {{PAD_W{1'b0}}, bank};
endmodule

// File: rtl/dau_ptr_reg.sv
module dau_ptr_reg #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PTR_W-1:0] wdata,
  output logic [PTR_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)     value <= '0;
    else if (we) value <= wdata;
  end
endmodule

// File: rtl/dau_resolve.sv
module dau_resolve
  import dau_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int OPND_W = 8,
  parameter int PTR_W  = 16
) (
  input  logic                     indirect,
  input  logic                     window,
  input  logic [OPND_W-1:0]        operand,
  input  logic [BANK_W-1:0]        bank,
  input  logic [PTR_W-1:0]         ptr,
  output logic [BANK_W+OPND_W-1:0] addr
);
  localparam int ADDR_W = BANK_W + OPND_W;

  addr_src_e         src;
  logic [BANK_W-1:0] win_bank;
  logic [ADDR_W-1:0] ptr_addr;
  logic              unused_ptr_hi;

  // Window upper bits: each copies the operand MSB, so the lower half of
  // the window lands in bank 0 and the upper half in the top bank.
  for (genvar i = 0; i < BANK_W; i++) begin : g_win
    assign win_bank[i] = operand[OPND_W-1];
  end

  if (PTR_W > ADDR_W) begin : g_ptr_trunc
    assign ptr_addr      = ptr[ADDR_W-1:0];
    assign unused_ptr_hi = ^ptr[PTR_W-1:ADDR_W];
  end else begin : g_ptr_ext
    assign ptr_addr      = ADDR_W'(ptr);
    assign unused_ptr_hi = 1'b0;
  end

  assign src = pick_src(indirect, window);

  always_comb begin
    unique case (src)
      SRC_POINTER: addr = ptr_addr;
      SRC_WINDOW:  addr = {win_bank, operand};
      default:     addr = {bank, operand};
    endcase
  end
endmodule

// File: rtl/dau_byte_ram.sv
module dau_byte_ram #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (req && we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (req) rdata <= mem[addr];
  end
endmodule

// File: rtl/dmem_addr_unit.sv
module dmem_addr_unit #(
  parameter int BANK_W = 4,
  parameter int OPND_W = 8,
  parameter int REG_W  = 8,
  parameter int PTR_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bank_we,
  input  logic [REG_W-1:0]         bank_wdata,
  input  logic                     ptr_we,
  input  logic [PTR_W-1:0]         ptr_wdata,
  input  logic                     indirect_i,
  input  logic                     access_i,
  input  logic [OPND_W-1:0]        operand_i,
  input  logic                     mem_req,
  input  logic                     mem_we,
  input  logic [DATA_W-1:0]        mem_wdata,
  output logic [BANK_W+OPND_W-1:0] addr_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [REG_W-1:0]         bank_o,
  output logic [PTR_W-1:0]         ptr_o
);
  localparam int ADDR_W = BANK_W + OPND_W;

  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_c;

  dau_bank_reg #(.BANK_W(BANK_W), .REG_W(REG_W)) u_bank (
    .clk(clk), .rst(rst), .we(bank_we), .wdata(bank_wdata),
    .bank(bank_q), .readback(bank_o)
  );

  dau_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .we(ptr_we), .wdata(ptr_wdata), .value(ptr_o)
  );

  dau_resolve #(.BANK_W(BANK_W), .OPND_W(OPND_W), .PTR_W(PTR_W)) u_res (
    .indirect(indirect_i), .window(access_i), .operand(operand_i),
    .bank(bank_q), .ptr(ptr_o), .addr(addr_c)
  );

  dau_byte_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk(clk), .rst(rst), .req(mem_req), .we(mem_we),
    .addr(addr_c), .wdata(mem_wdata), .rdata(rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_o <= '0;
    else     addr_o <= addr_c;
  end
endmodule

// File: rtl/dau_checker.sv
module dau_checker #(
  parameter int BANK_W = 4,
  parameter int OPND_W = 8,
  parameter int REG_W  = 8,
  parameter int PTR_W  = 16,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bank_we,
  input logic [REG_W-1:0]         bank_wdata,
  input logic                     ptr_we,
  input logic [PTR_W-1:0]         ptr_wdata,
  input logic                     indirect_i,
  input logic                     access_i,
  input logic [OPND_W-1:0]        operand_i,
  input logic                     mem_req,
  input logic                     mem_we,
  input logic [DATA_W-1:0]        mem_wdata,
  input logic [BANK_W+OPND_W-1:0] addr_o,
  input logic [DATA_W-1:0]        rdata_o,
  input logic [REG_W-1:0]         bank_o,
  input logic [PTR_W-1:0]         ptr_o
);
  localparam int ADDR_W = BANK_W + OPND_W;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && rdata_o == '0 && bank_o == '0 && ptr_o == '0));

  a_r2_direct_join: assert property (@(posedge clk) disable iff (rst)
    (!indirect_i && !access_i) |=>
      addr_o == {$past(bank_o[BANK_W-1:0]), $past(operand_i)});

  a_r3_r4_window: assert property (@(posedge clk) disable iff (rst)
    (!indirect_i && access_i) |=>
      (addr_o[OPND_W-1:0] == $past(operand_i) &&
       addr_o[ADDR_W-1:OPND_W] == {BANK_W{$past(operand_i[OPND_W-1])}}));

  a_r5_pointer: assert property (@(posedge clk) disable iff (rst)
    indirect_i |=> addr_o == $past(ptr_o[ADDR_W-1:0]));

  a_r6_bank_upper_zero: assert property (@(posedge clk) disable iff (rst)
    bank_o[REG_W-1:BANK_W] == '0);

  a_r6_bank_load: assert property (@(posedge clk) disable iff (rst)
    bank_we |=> bank_o[BANK_W-1:0] == $past(bank_wdata[BANK_W-1:0]));

  a_r7_ptr_load: assert property (@(posedge clk) disable iff (rst)
    ptr_we |=> ptr_o == $past(ptr_wdata));

  a_r9_read_hold: assert property (@(posedge clk) disable iff (rst)
    !mem_req |=> $stable(rdata_o));
endmodule

bind dmem_addr_unit dau_checker #(
  .BANK_W(BANK_W), .OPND_W(OPND_W), .REG_W(REG_W),
  .PTR_W(PTR_W), .DATA_W(DATA_W)
) i_chk (.*);

// File: tb/test_dmem_addr_unit.sv
module test_dmem_addr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        bank_we;
  logic [7:0]  bank_wdata;
  logic        ptr_we;
  logic [15:0] ptr_wdata;
  logic        indirect_i;
  logic        access_i;
  logic [7:0]  operand_i;
  logic        mem_req;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [11:0] addr_o;
  logic [7:0]  rdata_o;
  logic [7:0]  bank_o;
  logic [15:0] ptr_o;

  dmem_addr_unit i_dmem_addr_unit (
    .clk(clk), .rst(rst), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .indirect_i(indirect_i),
    .access_i(access_i), .operand_i(operand_i), .mem_req(mem_req),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .addr_o(addr_o),
    .rdata_o(rdata_o), .bank_o(bank_o), .ptr_o(ptr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // Reference model state
  int m_bank = 0;
  int m_ptr  = 0;
  int m_mem [int];
  int e_addr = 0;
  int e_rd   = 0;
  bit e_rd_known = 1;
  int lcg = 32'h1234_5678;

  function automatic int next_rand();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 8) & 32'hFFFF;
  endfunction

  function automatic int resolve(bit ind, bit acc, int op);
    if (ind) return m_ptr & 'hFFF;
    if (acc) return (op & 'h80) != 0 ? ('hF00 | op) : op;
    return (m_bank << 8) | op;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One clock: drive at the current falling edge, model the rising edge,
  // compare at the next falling edge.
  task automatic cyc(string tag, bit r, bit bwe, int bwd, bit pwe, int pwd,
                     bit ind, bit acc, int op, bit req, bit we, int wd);
    int a;
    rst = r; bank_we = bwe; bank_wdata = 8'(bwd); ptr_we = pwe;
    ptr_wdata = 16'(pwd); indirect_i = ind; access_i = acc;
    operand_i = 8'(op); mem_req = req; mem_we = we; mem_wdata = 8'(wd);
    a = resolve(ind, acc, op & 'hFF);
    if (req) begin
      if (m_mem.exists(a)) begin e_rd = m_mem[a]; e_rd_known = 1; end
      else e_rd_known = 0;
      if (we) m_mem[a] = wd & 'hFF;
    end
    if (r) begin
      m_bank = 0; m_ptr = 0; e_addr = 0; e_rd = 0; e_rd_known = 1;
    end else begin
      e_addr = a;
      if (bwe) m_bank = bwd & 'hF;
      if (pwe) m_ptr = pwd & 'hFFFF;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "addr", int'(addr_o), e_addr);
    check(tag, "bank_o", int'(bank_o), m_bank);
    check(tag, "ptr_o", int'(ptr_o), m_ptr);
    if (e_rd_known) check(tag, "rdata", int'(rdata_o), e_rd);
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; bank_we = 0; bank_wdata = 0; ptr_we = 0; ptr_wdata = 0;
    indirect_i = 0; access_i = 0; operand_i = 0; mem_req = 0; mem_we = 0;
    mem_wdata = 0;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) cyc("R1", 1, 1, 'hFF, 1, 'hFFFF, 0, 0, 'h33, 0, 0, 0);
    cyc("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R6: upper bank bits dropped
    cyc("R6", 0, 1, 'hA5, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R6", 0, 1, 'hF0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R8: bank write in the same cycle as a direct use -> old bank (0)
    cyc("R8_R2", 0, 1, 'h03, 0, 0, 0, 0, 'h44, 0, 0, 0);
    cyc("R8_R2", 0, 0, 0, 0, 0, 0, 0, 'h44, 0, 0, 0);

    // R2/R9: write one byte in every bank, then read them back
    for (int b = 0; b < 16; b++) begin
      cyc("R2", 0, 1, b, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc("R2_R9", 0, 0, 0, 0, 0, 0, 0, 'h20 + b, 1, 1, 'h10 + b * 3);
    end
    for (int b = 15; b >= 0; b--) begin
      cyc("R2", 0, 1, b, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc("R2_R9", 0, 0, 0, 0, 0, 0, 0, 'h20 + b, 1, 0, 0);
    end

    // R3/R4: window edges with a non-zero bank loaded
    cyc("R3", 0, 1, 7, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R3", 0, 0, 0, 0, 0, 0, 1, 'h00, 1, 1, 'h5A);
    cyc("R3", 0, 0, 0, 0, 0, 0, 1, 'h7F, 1, 1, 'h6B);
    cyc("R4", 0, 0, 0, 0, 0, 0, 1, 'h80, 1, 1, 'h7C);
    cyc("R4", 0, 0, 0, 0, 0, 0, 1, 'hFF, 1, 1, 'h8D);
    cyc("R3_R4", 0, 0, 0, 0, 0, 0, 1, 'h7F, 1, 0, 0);
    cyc("R3_R4", 0, 0, 0, 0, 0, 0, 1, 'h80, 1, 0, 0);

    // R10: window low half is bank 0; window high half is bank 15
    cyc("R10", 0, 0, 0, 0, 0, 0, 1, 'h10, 1, 1, 'hC3);
    cyc("R10", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 'h10, 1, 0, 0);
    cyc("R10", 0, 0, 0, 1, 'hF85, 0, 0, 0, 0, 0, 0);
    cyc("R10_R5", 0, 0, 0, 0, 0, 1, 0, 0, 1, 1, 'h99);
    cyc("R10", 0, 0, 0, 0, 0, 0, 1, 'h85, 1, 0, 0);

    // R7/R5: full pointer kept, only low 12 bits address; operand ignored
    cyc("R7", 0, 0, 0, 1, 'hABCD, 0, 0, 0, 0, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0, 1, 1, 'hFF, 0, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0, 1, 0, 'h12, 1, 1, 'h3E);
    // R8: pointer write and indirect use in the same cycle -> old pointer
    cyc("R8_R5", 0, 0, 0, 1, 'h0123, 1, 0, 0, 1, 0, 0);
    cyc("R8_R5", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);

    // R9: write cycle returns old byte, hold when idle
    cyc("R9", 0, 0, 0, 0, 0, 1, 0, 0, 1, 1, 'h11);
    cyc("R9", 0, 0, 0, 0, 0, 1, 0, 0, 1, 1, 'h22);
    cyc("R9", 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 0);
    cyc("R9", 0, 0, 0, 0, 0, 0, 1, 'h44, 0, 1, 'hEE);
    cyc("R9", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);

    // Mixed traffic over all modes
    for (int i = 0; i < 400; i++) begin
      int r1 = next_rand();
      int r2 = next_rand();
      int r3 = next_rand();
      cyc("R2_R3_R4_R5_R9", 0, (r1 & 7) == 0, r2 & 'hFF, (r1 & 15) == 1, r3,
          (r1 >> 4) & 1, (r1 >> 5) & 1, r2 >> 8, (r1 >> 6) & 1, (r1 >> 7) & 1,
          r3 & 'hFF);
    end

    // R1: reset mid-run clears registers again
    cyc("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R1", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule